// File: doc/BRIEF.md
# Instruction Fetch Memory Read Handshake Controller

This block is a bus master that fetches one instruction word from a memory whose response time is not fixed. A fetch begins when a start request arrives together with an address while the controller is idle. The address is first registered into a memory address register. The registered address is then placed on the address bus, and the read strobes are raised. The controller holds the request for as many cycles as the memory needs, until the memory raises its acknowledge.

When the acknowledge is seen, the data bus is registered into a memory data register and the strobes are withdrawn. One cycle later the memory data register is copied into the instruction register, and a one-cycle done pulse marks the new instruction. Before a new fetch may begin, the memory must drop its acknowledge. A start that arrives while a fetch is in flight, or while the acknowledge is still high, has no effect.

Top module: `fetch_handshake_ctrl`

## Requirements
- R1: After reset, abus_o, abus_oe_o, rw_o, ce_o, done_o, mdr_o and ir_o are all zero.
- R2: A start sampled while idle with ack_i low loads addr_i into the address register. In the following cycle abus_o equals that address and abus_oe_o is 1.
- R3: Whenever abus_oe_o is 0, abus_o reads as all zeros.
- R4: A read is signalled by rw_o=1 together with ce_o=1. The controller asserts rw_o, ce_o and abus_oe_o together and drops them together.
- R5: The request is held for any number of cycles until ack_i=1 is sampled. With the memory raising ack_i L cycles after the strobes first appear, done_o is high exactly L+3 cycles after the start cycle.
- R6: On the clock edge that samples ack_i=1 during a request, rdata_i is captured into mdr_o, and ce_o, rw_o and abus_oe_o return to 0 in the next cycle.
- R7: One cycle after that capture, ir_o takes the value of mdr_o and done_o is high for exactly one cycle.
- R8: After an access ends, no new start is accepted until ack_i has been sampled low. A start during that time leaves ce_o at 0.
- R9: A start received during a request is ignored. abus_o keeps the original address, and the fetch produces exactly one done pulse carrying the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Fetch request, sampled while idle |
| addr_i | input | ADDR_W | Fetch address, sampled with start_i |
| ack_i | input | 1 | Memory acknowledge; data bus valid while high |
| rdata_i | input | DATA_W | Memory data bus |
| abus_o | output | ADDR_W | Address bus, zero when not enabled |
| abus_oe_o | output | 1 | Address bus output enable |
| rw_o | output | 1 | Read strobe (1 = read) |
| ce_o | output | 1 | Memory chip enable |
| mdr_o | output | DATA_W | Memory data register contents |
| ir_o | output | DATA_W | Instruction register contents |
| done_o | output | 1 | One-cycle pulse when ir_o has been updated |

## Verification
The strobes and the address are due one cycle after the start cycle. mdr_o is due one cycle after the acknowledge is sampled, and ir_o and done_o are due one cycle after that, so done_o appears L+3 cycles after the start cycle for a memory latency of L. The bench drives inputs on falling edges and samples on falling edges. It counts falling edges from the start to the done pulse and compares the count with L+3. A queue holds each expected word, which is pushed at start time and popped and compared against ir_o and mdr_o on the done pulse. The ignored starts are checked on the falling edge right after they are sampled, by reading abus_o or ce_o.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_MOVE  = 2'd2,
        ST_DRAIN = 2'd3
    } fhc_state_e;

    typedef struct packed {
        fhc_state_e state;
        logic       done;
    } fhc_seq_t;
endpackage

// File: rtl/fhc_seq.sv
module fhc_seq
    import fhc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_i,
    output logic load_mar_o,
    output logic cap_mdr_o,
    output logic load_ir_o,
    output logic bus_on_o,
    output logic done_o
);
    fhc_seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                // a lingering acknowledge blocks the next fetch
                if (start_i && !ack_i) seq_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (ack_i) seq_d.state = ST_MOVE;
            end
            ST_MOVE: begin
                seq_d.done  = 1'b1;
                seq_d.state = ack_i ? ST_DRAIN : ST_IDLE;
            end
            default: begin
                if (!ack_i) seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign load_mar_o = (seq_q.state == ST_IDLE) && start_i && !ack_i;
    assign cap_mdr_o  = (seq_q.state == ST_REQ) && ack_i;
    assign load_ir_o  = (seq_q.state == ST_MOVE);
    assign bus_on_o   = (seq_q.state == ST_REQ);
    assign done_o     = seq_q.done;
endmodule

// File: rtl/fhc_regs.sv
module fhc_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mar_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cap_mdr_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              load_ir_i,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] mdr_o,
    output logic [DATA_W-1:0] ir_o
);
    logic [ADDR_W-1:0] mar_d, mar_q;
    logic [DATA_W-1:0] mdr_d, mdr_q;
    logic [DATA_W-1:0] ir_d,  ir_q;

    always_comb begin
        mar_d = load_mar_i ? addr_i  : mar_q;
        mdr_d = cap_mdr_i  ? rdata_i : mdr_q;
        ir_d  = load_ir_i  ? mdr_q   : ir_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            mar_q <= mar_d;
            mdr_q <= mdr_d;
            ir_q  <= ir_d;
        end
    end

    assign mar_o = mar_q;
    assign mdr_o = mdr_q;
    assign ir_o  = ir_q;
endmodule

// File: rtl/fhc_bus_drive.sv
module fhc_bus_drive #(
    parameter int ADDR_W = 12
) (
    input  logic              bus_on_i,
    input  logic [ADDR_W-1:0] mar_i,
    output logic [ADDR_W-1:0] abus_o,
    output logic              abus_oe_o,
    output logic              rw_o,
    output logic              ce_o
);
    always_comb begin
        abus_oe_o = bus_on_i;
        rw_o      = bus_on_i;
        ce_o      = bus_on_i;
        abus_o    = bus_on_i ? mar_i : '0;
    end
endmodule

// File: rtl/fetch_handshake_ctrl.sv
module fetch_handshake_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] abus_o,
    output logic              abus_oe_o,
    output logic              rw_o,
    output logic              ce_o,
    output logic [DATA_W-1:0] mdr_o,
    output logic [DATA_W-1:0] ir_o,
    output logic              done_o
);
    logic              load_mar, cap_mdr, load_ir, bus_on;
    logic [ADDR_W-1:0] mar;

    fhc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (ack_i),
        .load_mar_o (load_mar),
        .cap_mdr_o  (cap_mdr),
        .load_ir_o  (load_ir),
        .bus_on_o   (bus_on),
        .done_o     (done_o)
    );

    fhc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_mar_i (load_mar),
        .addr_i     (addr_i),
        .cap_mdr_i  (cap_mdr),
        .rdata_i    (rdata_i),
        .load_ir_i  (load_ir),
        .mar_o      (mar),
        .mdr_o      (mdr_o),
        .ir_o       (ir_o)
    );

    fhc_bus_drive #(.ADDR_W(ADDR_W)) u_drive (
        .bus_on_i  (bus_on),
        .mar_i     (mar),
        .abus_o    (abus_o),
        .abus_oe_o (abus_oe_o),
        .rw_o      (rw_o),
        .ce_o      (ce_o)
    );
endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ack_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic [ADDR_W-1:0] abus_o,
    input logic              abus_oe_o,
    input logic              rw_o,
    input logic              ce_o,
    input logic [DATA_W-1:0] mdr_o,
    input logic [DATA_W-1:0] ir_o,
    input logic              done_o
);
    AST_START_DRIVES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_o) |-> ($past(start_i) && abus_oe_o && abus_o == $past(addr_i))); // R2

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !abus_oe_o |-> (abus_o == '0)); // R3

    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o == rw_o) && (ce_o == abus_oe_o)); // R4

    AST_HOLD_FOR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && !ack_i) |=> (ce_o && $stable(abus_o))); // R5

    AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && ack_i) |=> (!ce_o && mdr_o == $past(rdata_i))); // R6

    AST_IR_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && ack_i) |=> ##1 (done_o && ir_o == $past(mdr_o))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_WAIT_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_o && ack_i) |=> !ce_o); // R8
endmodule

bind fetch_handshake_ctrl fhc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fhc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .ack_i     (ack_i),
    .rdata_i   (rdata_i),
    .abus_o    (abus_o),
    .abus_oe_o (abus_oe_o),
    .rw_o      (rw_o),
    .ce_o      (ce_o),
    .mdr_o     (mdr_o),
    .ir_o      (ir_o),
    .done_o    (done_o)
);

// File: tb/fetch_handshake_ctrl_test.sv
`timescale 1ns/1ps
module fetch_handshake_ctrl_test;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          ack_i = 1'b0;
    logic [DW-1:0] rdata_i = '0;
    logic [AW-1:0] abus_o;
    logic          abus_oe_o, rw_o, ce_o, done_o;
    logic [DW-1:0] mdr_o, ir_o;

    int checks = 0;
    int errors = 0;
    int lat_v  = 0;
    int hold_v = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    fetch_handshake_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .ack_i(ack_i), .rdata_i(rdata_i), .abus_o(abus_o), .abus_oe_o(abus_oe_o),
        .rw_o(rw_o), .ce_o(ce_o), .mdr_o(mdr_o), .ir_o(ir_o), .done_o(done_o)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return 16'(a * 16'h9E37 + 16'h1234);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: ack after lat_v cycles of ce, held hold_v cycles after ce drops
    int cnt = 0;
    int hcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ack_i = 1'b0; cnt = 0; hcnt = 0;
        end else if (ce_o && !ack_i) begin
            if (cnt >= lat_v) begin
                ack_i = 1'b1; rdata_i = memf(abus_o);
            end else cnt++;
        end else if (!ce_o && ack_i) begin
            if (hcnt >= hold_v) begin
                ack_i = 1'b0; cnt = 0; hcnt = 0; rdata_i = 16'hDEAD;
            end else hcnt++;
        end
    end

    // monitor: scoreboard pop on each done pulse
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (exp_q.size() == 0) check(1'b0, "R9 unexpected done", 1, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(mdr_o == e, "R6 mdr capture", int'(mdr_o), int'(e));
                    check(ir_o == e, "R7 ir copy", int'(ir_o), int'(e));
                end
            end
            if (done_o && prev_done) check(1'b0, "R7 done longer than one cycle", 1, 0);
            prev_done = done_o;
        end
    end

    task automatic fetch(input logic [AW-1:0] a, input int lat, input int hold, input bit busy);
        int n;
        lat_v = lat; hold_v = hold;
        exp_q.push_back(memf(a));
        start_i = 1'b1; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        check(abus_o == a && abus_oe_o, "R2 address on bus", int'(abus_o), int'(a));
        check(rw_o && ce_o && abus_oe_o, "R4 read strobes", {rw_o, ce_o, abus_oe_o}, 3'b111);
        n = 1;
        while (!done_o && n < 500) begin
            if (busy && n == 2) begin
                start_i = 1'b1; addr_i = ~a;
            end
            @(negedge clk);
            n++;
            if (start_i) begin
                start_i = 1'b0;
                check(abus_o == a, "R9 busy start ignored", int'(abus_o), int'(a));
            end
        end
        check(n == lat + 3, "R5 latency to done", n, lat + 3);
        if (hold >= 2) begin
            start_i = 1'b1; addr_i = a + 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(!ce_o, "R8 start while ack high ignored", int'(ce_o), 0);
        end
        while (ack_i) @(negedge clk);
        @(negedge clk);
        check(!ce_o && !abus_oe_o && abus_o == '0, "R3 bus idle zero", int'(abus_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(abus_o == '0 && !abus_oe_o && !rw_o && !ce_o && !done_o,
              "R1 reset controls", {abus_oe_o, rw_o, ce_o, done_o}, 0);
        check(mdr_o == '0 && ir_o == '0, "R1 reset registers", int'(ir_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        fetch(12'h5AF, 0, 0, 1'b0);
        fetch(12'h000, 3, 0, 1'b0);
        fetch(12'hFFF, 5, 1, 1'b1);
        fetch(12'h32E, 1, 4, 1'b0);
        fetch(12'h9AC, 40, 2, 1'b1);
        fetch(12'h123, 2, 0, 1'b0);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9 one done per fetch", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule